// File: doc/BRIEF.md
# Circular pre-trigger delay buffer

This block is a programmable digital delay line built on a circular store held in an internal memory array. Each accepted sample strobe reads out the word held at the current location and then overwrites that location with the incoming word. The location pointer counts downward and wraps at a programmable length N. Every word therefore reappears at the output exactly N accepted samples after it went in, and N is independent of how often samples arrive.

A trigger input lets the block capture history that came before an event. The trigger passes through a synchroniser and an edge detector, and its rising edge arms a post-trigger countdown loaded with a programmed count B. Once B more samples have been written, capture freezes. The memory then holds the last N words: the pre-trigger history plus the B post-trigger words. A registered read port returns any frozen location by address. A re-arm strobe resumes capture without clearing the memory.

Top module: `pretrig_delay_line`

## Requirements
- R1: On an accepted sample (sample high, not stopped, and neither cfg_load nor rearm high), dout takes the word previously stored at the current location on the next edge, and din is written into that same location.
- R2: The location pointer starts at N and moves down by one on each written sample. A written sample at location 1 reloads the pointer to N, so only locations 1..N are used.
- R3: A word written on one accepted sample appears on dout on the Nth following accepted sample. N equal to 1 gives a one-sample delay. The first N outputs after a load are old memory contents.
- R4: cfg_load latches cfg_len as N, with 0 taken as 1 and values above DEPTH taken as DEPTH, and latches cfg_post as B. It also sets the pointer to N and the countdown to B, and clears the stopped state and the trigger flag. A sample strobe in the same cycle is ignored.
- R5: trig_in passes through two synchronising flops. Its rising edge sets a sticky trigger flag while capture is running. The countdown decrements only on written samples while the flag is set.
- R6: When the countdown reaches zero, stopped goes high. After that no writes occur, and dout and the pointer hold until cfg_load or rearm. With B equal to 0, the first sample after the trigger writes nothing and stops capture at once.
- R7: done is high for exactly one cycle, in the cycle in which stopped first becomes high.
- R8: rearm sets the pointer to N and the countdown to B, and clears the stopped state and the flag. Memory contents are kept, so later outputs return the words held before the re-arm.
- R9: rd_data returns, one cycle later, the word stored at location rd_addr (1..DEPTH). Any other address returns 0. A read does not disturb the memory.
- R10: After reset, dout, rd_data, stopped and done are 0, N is DEPTH and B is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 1 | Sample strobe, one clock wide per sample |
| din | input | DATA_W | Incoming sample word |
| dout | output | DATA_W | Delayed word, updated on each accepted sample |
| trig_in | input | 1 | Asynchronous trigger level |
| cfg_load | input | 1 | Latch new N and B and restart capture |
| cfg_len | input | $clog2(DEPTH+1) | Delay length N |
| cfg_post | input | CNT_W | Post-trigger sample count B |
| rearm | input | 1 | Restart capture with the current N and B |
| rd_addr | input | $clog2(DEPTH+1) | Readback location |
| rd_data | output | DATA_W | Readback word, one cycle after rd_addr |
| stopped | output | 1 | Capture is frozen |
| done | output | 1 | One-cycle pulse when capture freezes |

## Verification
The assertions check the cycle-level invariants on every cycle. They cover the pointer staying within 1..N and stepping or wrapping on each written sample, the countdown holding whenever the flag is clear, the freeze of pointer and output while stopped, the single-cycle done pulse tied to the rise of stopped, and the state restored by a load or re-arm. Only the bench's scenarios can show the data itself. This includes the exact N-sample delay for several lengths including 1 and the clamped extremes, the number of post-trigger words kept, the B=0 stop that writes nothing, memory kept across a re-arm, and readback of the frozen contents.

// File: rtl/pretrig_delay_line.sv
module pretrig_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic              trig_in,
  input  logic              cfg_load,
  input  logic [AW-1:0]     cfg_len,
  input  logic [CNT_W-1:0]  cfg_post,
  input  logic              rearm,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              stopped,
  output logic              done
);
  localparam int MEM_SZ = 1 << AW;
  localparam logic [AW-1:0] LEN_MAX = AW'(DEPTH);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [DATA_W-1:0] mem [MEM_SZ];
  logic [AW-1:0]     len, ptr;
  logic [CNT_W-1:0]  post, cnt;
  logic              flag;
  logic [2:0]        trig_sync;

  wire trig_edge = trig_sync[1] & ~trig_sync[2];
  wire [AW-1:0] len_clamped = (cfg_len == '0) ? ONE :
                              (cfg_len > LEN_MAX) ? LEN_MAX : cfg_len;
  wire restart   = cfg_load | rearm;
  wire take      = sample & ~stopped & ~restart;
  wire stop_now  = flag & (cnt == '0);
  wire wr_en     = take & ~stop_now;
  wire last_post = flag & (cnt == CNT_W'(1));
  wire [AW-1:0] ptr_nxt = (ptr == ONE) ? len : ptr - ONE;
  wire rd_ok = (rd_addr != '0) && (rd_addr <= LEN_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) trig_sync <= '0;
    else        trig_sync <= {trig_sync[1:0], trig_in};
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len     <= LEN_MAX;
      post    <= '0;
      ptr     <= LEN_MAX;
      cnt     <= '0;
      flag    <= 1'b0;
      stopped <= 1'b0;
      done    <= 1'b0;
      dout    <= '0;
      rd_data <= '0;
    end else begin
      done    <= 1'b0;
      rd_data <= rd_ok ? mem[rd_addr] : '0;
      if (cfg_load) begin
        len  <= len_clamped;
        post <= cfg_post;
        ptr  <= len_clamped;
        cnt  <= cfg_post;
      end else if (rearm) begin
        ptr  <= len;
        cnt  <= post;
      end
      if (restart) begin
        flag    <= 1'b0;
        stopped <= 1'b0;
      end else begin
        if (trig_edge && !stopped) flag <= 1'b1;
        if (take && stop_now) begin
          stopped <= 1'b1;
          done    <= 1'b1;
        end
        if (wr_en) begin
          dout <= mem[ptr];
          ptr  <= ptr_nxt;
          if (flag) begin
            cnt <= cnt - CNT_W'(1);
            if (last_post) begin
              stopped <= 1'b1;
              done    <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pretrig_delay_line_chk.sv
module pretrig_delay_line_chk #(
  parameter int AW     = 7,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample,
  input logic              cfg_load,
  input logic              rearm,
  input logic              stopped,
  input logic              done,
  input logic              flag,
  input logic [AW-1:0]     ptr,
  input logic [AW-1:0]     len,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] dout
);
  localparam logic [AW-1:0] ONE = AW'(1);

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr >= ONE) && (ptr <= len));

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !stopped && !cfg_load && !rearm && !(flag && cnt == '0))
    |=> (ptr == (($past(ptr) == ONE) ? $past(len) : $past(ptr) - ONE)));

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!flag || !sample || stopped) && !cfg_load && !rearm) |=> $stable(cnt));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !cfg_load && !rearm) |=> (stopped && $stable(ptr) && $stable(dout)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> done);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm || cfg_load) |=> (!stopped && !flag && ptr == len));
endmodule

bind pretrig_delay_line pretrig_delay_line_chk #(
  .AW(AW), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample(sample), .cfg_load(cfg_load),
  .rearm(rearm), .stopped(stopped), .done(done), .flag(flag),
  .ptr(ptr), .len(len), .cnt(cnt), .dout(dout)
);

// File: tb/pretrig_delay_line_tb.sv
`timescale 1ns/1ps
module pretrig_delay_line_tb;
  localparam int DW = 16, DEPTH = 16, CW = 8;
  localparam int AW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sample, trig_in, cfg_load, rearm, stopped, done;
  logic [DW-1:0] din, dout, rd_data;
  logic [AW-1:0] cfg_len, rd_addr;
  logic [CW-1:0] cfg_post;

  pretrig_delay_line #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample(sample), .din(din), .dout(dout),
    .trig_in(trig_in), .cfg_load(cfg_load), .cfg_len(cfg_len),
    .cfg_post(cfg_post), .rearm(rearm), .rd_addr(rd_addr),
    .rd_data(rd_data), .stopped(stopped), .done(done));

  int vectors = 0, miscompares = 0, seq = 0;
  bit finished = 0;
  int m_mem [0:DEPTH];
  bit m_kn  [0:DEPTH];
  int m_len, m_post, m_ptr, m_cnt, m_dout, m_rd;
  bit m_flag, m_stopped, m_done, m_dk, m_rdk;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit smp, int d, bit ld = 0, int l = 0, int b = 0,
                      bit rn = 0, int ra = 0);
    sample = smp; din = d[DW-1:0]; cfg_load = ld; cfg_len = l[AW-1:0];
    cfg_post = b[CW-1:0]; rearm = rn; rd_addr = ra[AW-1:0];
    @(posedge clk);
    m_done = 0;
    if (ra >= 1 && ra <= DEPTH) begin m_rd = m_mem[ra]; m_rdk = m_kn[ra]; end
    else begin m_rd = 0; m_rdk = 1; end
    if (ld) begin
      m_len = (l == 0) ? 1 : (l > DEPTH) ? DEPTH : l;
      m_post = b; m_ptr = m_len; m_cnt = m_post; m_flag = 0; m_stopped = 0;
    end else if (rn) begin
      m_ptr = m_len; m_cnt = m_post; m_flag = 0; m_stopped = 0;
    end else if (smp && !m_stopped) begin
      if (m_flag && m_cnt == 0) begin
        m_stopped = 1; m_done = 1;
      end else begin
        m_dout = m_mem[m_ptr]; m_dk = m_kn[m_ptr];
        m_mem[m_ptr] = d & 16'hFFFF; m_kn[m_ptr] = 1;
        m_ptr = (m_ptr == 1) ? m_len : m_ptr - 1;
        if (m_flag) begin
          m_cnt--;
          if (m_cnt == 0) begin m_stopped = 1; m_done = 1; end
        end
      end
    end
    @(negedge clk);
    chk("R6 stopped", int'(stopped), int'(m_stopped));
    chk("R7 done", int'(done), int'(m_done));
    if (m_dk)  chk("R1 R3 dout", int'(dout), m_dout);
    if (m_rdk) chk("R9 rd_data", int'(rd_data), m_rd);
  endtask

  task automatic feed(int n);
    for (int i = 0; i < n; i++) begin
      seq++;
      step(1, (seq * 37 + 11) & 16'hFFFF);
      if (i % 5 == 3) step(0, 0);
    end
  endtask

  task automatic fire();
    trig_in = 1; step(0, 0);
    trig_in = 0; step(0, 0); step(0, 0); step(0, 0);
    if (!m_stopped) m_flag = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int cnt_acc, keep;
    rst_n = 0; sample = 0; din = '0; trig_in = 0; cfg_load = 0; rearm = 0;
    cfg_len = '0; cfg_post = '0; rd_addr = '0;
    for (int i = 0; i <= DEPTH; i++) begin m_mem[i] = 0; m_kn[i] = 0; end
    m_len = DEPTH; m_ptr = DEPTH; m_post = 0; m_cnt = 0; m_flag = 0;
    m_stopped = 0; m_done = 0; m_dout = 0; m_dk = 1; m_rd = 0; m_rdk = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 dout after reset", int'(dout), 0);
    chk("R10 stopped after reset", int'(stopped), 0);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 rd_data after reset", int'(rd_data), 0);

    // R1 R2 R3 delay of 5, pre-trigger samples leave the countdown alone (R5)
    step(0, 0, 1, 5, 3);
    feed(22);
    chk("R5 no stop before trigger", int'(stopped), 0);

    // R4 sample in the load cycle is ignored
    step(1, 999, 1, 5, 3);
    feed(7);

    // R5 R6 three post-trigger words then freeze
    fire();
    cnt_acc = 0;
    for (int i = 0; i < 6; i++) begin
      if (!stopped) cnt_acc++;
      seq++; step(1, seq * 13 + 5);
    end
    chk("R5 samples written after trigger", cnt_acc, 3);

    // R9 readback of the frozen store, out-of-range addresses read 0
    for (int a = 0; a <= 6; a++) step(0, 0, 0, 0, 0, 0, a);
    step(0, 0, 0, 0, 0, 0, 20);
    chk("R9 out-of-range read", int'(rd_data), 0);

    // R8 re-arm keeps memory
    step(0, 0, 0, 0, 0, 1);
    keep = m_mem[m_len];
    seq++; step(1, seq * 3);
    chk("R8 retained word after rearm", int'(dout), keep);
    feed(9);

    // R3 one-sample delay
    step(0, 0, 1, 1, 0);
    feed(8);
    // R4 clamping of 0 and of an oversized length
    step(0, 0, 1, 0, 0);
    feed(6);
    step(0, 0, 1, 31, 2);
    feed(40);
    fire();
    feed(5);
    for (int a = 1; a <= DEPTH; a++) step(0, 0, 0, 0, 0, 0, a);

    // R6 B=0: first flagged sample stops capture without writing
    step(0, 0, 1, 4, 0);
    feed(4);
    fire();
    keep = m_mem[m_ptr];
    step(1, 4321);
    chk("R6 B=0 stop pulse", int'(stopped), 1);
    step(0, 0, 0, 0, 0, 0, 4);
    chk("R6 B=0 no write at location 4", int'(rd_data), keep);
    step(1, 777);

    // R8 re-arm after B=0 stop resumes delay
    step(0, 0, 0, 0, 0, 1);
    chk("R8 stopped cleared", int'(stopped), 0);
    feed(10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule